// File: doc/BRIEF.md
# Platform Reset, APM Command and SMI Lock Control

This block collects three small control registers of a platform controller behind one byte-wide register bus. The first is a reset control byte. A write that sets its fire bit asks for a system reset, and the write leaves the stored value alone. Any other write keeps only the full-reset and system-reset flags. The second is an APM command port. Two special command codes switch ACPI mode on and off. Every other code raises a system management interrupt (SMI), provided the APM-command enable is set in the SMI enable register.

The third part is a power-management control register. It carries a sticky SMI lock. Once the lock is set, neither the lock itself nor the global SMI enable bit can be changed until block reset. A 16-bit power-management I/O base register sits beside it and keeps only its base-address bits. Every register reads back combinationally on the same bus. The reset request and the SMI request leave the block as one-cycle pulses, and the ACPI mode leaves as a level.

Top module: `plat_ctl_top`

## Requirements
- R1: After reset every register reads 0x00, `acpi_mode` is 0 and both request outputs are 0. The reset control byte (address 0) reads back its stored value.
- R2: A write to address 0 with bit 2 set drives `rst_req` high in the cycle after the write, and the stored byte keeps its previous value.
- R3: A write to address 0 with bit 2 clear stores `wdata & 0x0A`, so only bit 3 and bit 1 are kept and every other bit reads 0.
- R4: A write of `ACPI_ON_CODE` to the APM port (address 1) sets `acpi_mode`, and a write of `ACPI_OFF_CODE` clears it. Neither code raises `smi_req`. The port reads back the last command written.
- R5: A write of any other code to address 1 drives `smi_req` high in the cycle after the write if bit 5 (APM-command enable) of the SMI enable register (address 2) is 1, and leaves it low otherwise. Such a write leaves `acpi_mode` unchanged.
- R6: Bit 4 of the PM control register (address 3) is the SMI lock. Writing it to 1 sets it, and it then reads 1 and ignores writes of 0 until block reset. The other bits of that register stay writable.
- R7: While the lock is set, bit 0 (global SMI enable) of address 2 keeps its value and the other bits of address 2 remain writable. Before the lock is set, bit 0 is freely writable.
- R8: The PM I/O base register keeps only bits 15:7. Its low byte (address 4) stores `wdata & 0x80` and its high byte (address 5) stores all 8 bits.
- R9: `rst_req` and `smi_req` are single-cycle pulses. A request is high for exactly the one cycle after its triggering write.
- R10: Addresses 6 and 7 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | System reset request pulse |
| smi_req | output | 1 | SMI request pulse |
| acpi_mode | output | 1 | ACPI mode (SCI enable) level |

## Verification
Register contents and `acpi_mode` are due one edge after the write. Read data follows the address combinationally, so the bench moves the address at a falling edge and samples a moment later. The `rst_req` and `smi_req` pulses are due in the cycle right after the writing edge. The bench therefore checks them at the falling edge that follows, and at the next falling edge it checks that they have dropped again. The reset control byte and the APM port are swept over all 256 data values, with the APM sweep run once with the enable set and once with it clear. The lock sequence checks the frozen bits after every write, both before and after the lock is set, and again across a later reset.

// File: rtl/plat_ctl_pkg.sv
package plat_ctl_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int BASE_W = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_RSTCTL  = 3'd0,
        A_APMCMD  = 3'd1,
        A_SMIEN   = 3'd2,
        A_PMCTL   = 3'd3,
        A_BASE_LO = 3'd4,
        A_BASE_HI = 3'd5
    } reg_addr_e;

    localparam int RST_FIRE_BIT = 2;
    localparam logic [DATA_W-1:0] RST_KEEP_MASK = 8'h0A;

    localparam int SMI_GBL_BIT = 0;
    localparam int APM_EN_BIT  = 5;
    localparam int LOCK_BIT    = 4;
    localparam int BASE_LSB    = 7;

    localparam logic [BASE_W-1:0] BASE_MASK = {BASE_W{1'b1}} << BASE_LSB;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_wr_t;

    function automatic logic wr_hit(bus_wr_t b, reg_addr_e a);
        return b.wr && (b.addr == a);
    endfunction

endpackage

// File: rtl/plat_rst_ctl.sv
module plat_rst_ctl
    import plat_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           bus,
    output logic [DATA_W-1:0] value,
    output logic              rst_req
);

    logic hit;
    logic fire;

    assign hit  = wr_hit(bus, A_RSTCTL);
    assign fire = hit && bus.data[RST_FIRE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            value   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= fire;
            if (hit && !fire) begin
                value <= bus.data & RST_KEEP_MASK;
            end
        end
    end

    assert_fire_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        fire |=> rst_req);

    assert_fire_keeps_value_R2: assert property (@(posedge clk) disable iff (rst)
        fire |=> $stable(value));

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(fire));

endmodule

// File: rtl/plat_apm_ctl.sv
module plat_apm_ctl
    import plat_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] ACPI_ON_CODE  = 8'hE1,
    parameter logic [DATA_W-1:0] ACPI_OFF_CODE = 8'h1E
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           bus,
    input  logic              apm_en,
    output logic [DATA_W-1:0] last_cmd,
    output logic              smi_req,
    output logic              acpi_mode
);

    typedef enum logic [1:0] {CMD_ON, CMD_OFF, CMD_SMI} cmd_kind_e;

    logic      hit;
    cmd_kind_e kind;

    assign hit = wr_hit(bus, A_APMCMD);

    always_comb begin
        if (bus.data == ACPI_ON_CODE)       kind = CMD_ON;
        else if (bus.data == ACPI_OFF_CODE) kind = CMD_OFF;
        else                                kind = CMD_SMI;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd  <= '0;
            smi_req   <= 1'b0;
            acpi_mode <= 1'b0;
        end else begin
            smi_req <= hit && (kind == CMD_SMI) && apm_en;
            if (hit) begin
                last_cmd <= bus.data;
                if (kind == CMD_ON)  acpi_mode <= 1'b1;
                if (kind == CMD_OFF) acpi_mode <= 1'b0;
            end
        end
    end

    assert_acpi_on_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && bus.data == ACPI_ON_CODE) |=> acpi_mode);

    assert_acpi_off_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && bus.data == ACPI_OFF_CODE) |=> !acpi_mode);

    assert_smi_cause_R5: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $past(hit && apm_en && bus.data != ACPI_ON_CODE
                          && bus.data != ACPI_OFF_CODE));

    assert_smi_keeps_mode_R5: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> $stable(acpi_mode));

endmodule

// File: rtl/plat_pm_regs.sv
module plat_pm_regs
    import plat_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_wr_t           bus,
    output logic [DATA_W-1:0] smi_en,
    output logic [DATA_W-1:0] pm_ctl,
    output logic [BASE_W-1:0] pm_base,
    output logic              apm_en
);

    logic locked;

    assign locked = pm_ctl[LOCK_BIT];
    assign apm_en = smi_en[APM_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            smi_en  <= '0;
            pm_ctl  <= '0;
            pm_base <= '0;
        end else begin
            if (wr_hit(bus, A_SMIEN)) begin
                smi_en <= bus.data;
                if (locked) smi_en[SMI_GBL_BIT] <= smi_en[SMI_GBL_BIT];
            end
            if (wr_hit(bus, A_PMCTL)) begin
                pm_ctl <= bus.data;
                pm_ctl[LOCK_BIT] <= locked | bus.data[LOCK_BIT];
            end
            if (wr_hit(bus, A_BASE_LO)) begin
                pm_base[DATA_W-1:0] <= bus.data & BASE_MASK[DATA_W-1:0];
            end
            if (wr_hit(bus, A_BASE_HI)) begin
                pm_base[BASE_W-1:DATA_W] <= bus.data & BASE_MASK[BASE_W-1:DATA_W];
            end
        end
    end

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> locked);

    assert_gbl_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> (smi_en[SMI_GBL_BIT] == $past(smi_en[SMI_GBL_BIT])));

    assert_base_align_R8: assert property (@(posedge clk) disable iff (rst)
        $past(wr_hit(bus, A_BASE_LO)) |-> (pm_base[BASE_LSB-1:0] == '0));

endmodule

// File: rtl/plat_ctl_top.sv
module plat_ctl_top
    import plat_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] ACPI_ON_CODE  = 8'hE1,
    parameter logic [DATA_W-1:0] ACPI_OFF_CODE = 8'h1E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req,
    output logic              smi_req,
    output logic              acpi_mode
);

    if (ACPI_ON_CODE == ACPI_OFF_CODE) begin : g_bad_codes
        $error("ACPI on and off command codes must differ");
    end

    bus_wr_t           bus;
    logic [DATA_W-1:0] rst_val;
    logic [DATA_W-1:0] apm_val;
    logic [DATA_W-1:0] smi_en;
    logic [DATA_W-1:0] pm_ctl;
    logic [BASE_W-1:0] pm_base;
    logic              apm_en;

    assign bus = '{wr: bus_wr, addr: bus_addr, data: bus_wdata};

    plat_rst_ctl u_rst (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .value   (rst_val),
        .rst_req (rst_req)
    );

    plat_apm_ctl #(
        .ACPI_ON_CODE  (ACPI_ON_CODE),
        .ACPI_OFF_CODE (ACPI_OFF_CODE)
    ) u_apm (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .apm_en    (apm_en),
        .last_cmd  (apm_val),
        .smi_req   (smi_req),
        .acpi_mode (acpi_mode)
    );

    plat_pm_regs u_pm (
        .clk     (clk),
        .rst     (rst),
        .bus     (bus),
        .smi_en  (smi_en),
        .pm_ctl  (pm_ctl),
        .pm_base (pm_base),
        .apm_en  (apm_en)
    );

    always_comb begin
        case (bus_addr)
            A_RSTCTL:  bus_rdata = rst_val;
            A_APMCMD:  bus_rdata = apm_val;
            A_SMIEN:   bus_rdata = smi_en;
            A_PMCTL:   bus_rdata = pm_ctl;
            A_BASE_LO: bus_rdata = pm_base[DATA_W-1:0];
            A_BASE_HI: bus_rdata = pm_base[BASE_W-1:DATA_W];
            default:   bus_rdata = '0;
        endcase
    end

    assert_req_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(rst_req && smi_req));

endmodule

// File: tb/test_plat_ctl_top.sv
`timescale 1ns/1ps
module test_plat_ctl_top;

    localparam logic [7:0] ON_C  = 8'hE1;
    localparam logic [7:0] OFF_C = 8'h1E;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       rst_req, smi_req, acpi_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    plat_ctl_top #(.ACPI_ON_CODE(ON_C), .ACPI_OFF_CODE(OFF_C)) i_plat_ctl_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
        .smi_req(smi_req), .acpi_mode(acpi_mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one-cycle write; returns at the falling edge after the capturing edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #900000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] exp_rst;
        logic       exp_acpi;
        logic [7:0] exp_smi_en;
        do_reset();

        // R1 reset state, R10 unused addresses
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            chk("R1 reset register value", r, 8'h00);
        end
        chk("R1 reset outputs", {5'd0, rst_req, smi_req, acpi_mode}, 8'h00);

        // R2/R3/R9 reset control byte sweep
        exp_rst = 8'h00;
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, v[7:0]);
            chk("R2 rst_req after write", {7'd0, rst_req}, {7'd0, v[2]});
            if (!v[2]) exp_rst = v[7:0] & 8'h0A;
            rd(3'd0, r);
            chk(v[2] ? "R2 stored byte kept" : "R3 stored byte masked", r, exp_rst);
            @(negedge clk);
            chk("R9 rst_req single cycle", {7'd0, rst_req}, 8'h00);
        end

        // R10 writes to unused addresses change nothing
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            chk("R10 no side effect", r, (a == 0) ? exp_rst : 8'h00);
        end

        // R7 global enable writable before lock, then R6 lock
        wr(3'd2, 8'h01); rd(3'd2, r); chk("R7 gbl writable set", r, 8'h01);
        wr(3'd2, 8'h00); rd(3'd2, r); chk("R7 gbl writable clear", r, 8'h00);
        wr(3'd3, 8'h0F); rd(3'd3, r); chk("R6 ctl without lock", r, 8'h0F);
        wr(3'd2, 8'h01);
        wr(3'd3, 8'h10); rd(3'd3, r); chk("R6 lock set", r, 8'h10);
        wr(3'd3, 8'h00); rd(3'd3, r); chk("R6 lock ignores clear", r, 8'h10);
        wr(3'd3, 8'hEF); rd(3'd3, r); chk("R6 other bits writable", r, 8'hFF);
        wr(3'd2, 8'h20); rd(3'd2, r); chk("R7 gbl frozen at 1", r, 8'h21);
        exp_smi_en = 8'h21;

        // R4/R5/R9 APM sweep with enable set, then clear
        exp_acpi = 1'b0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 256; v++) begin
                logic special;
                special = (v[7:0] == ON_C) || (v[7:0] == OFF_C);
                wr(3'd1, v[7:0]);
                if (v[7:0] == ON_C)  exp_acpi = 1'b1;
                if (v[7:0] == OFF_C) exp_acpi = 1'b0;
                chk(special ? "R4 no smi on mode code" : "R5 smi gating",
                    {7'd0, smi_req}, {7'd0, !special && exp_smi_en[5]});
                chk(special ? "R4 acpi mode" : "R5 acpi mode unchanged",
                    {7'd0, acpi_mode}, {7'd0, exp_acpi});
                rd(3'd1, r);
                chk("R4 last command readback", r, v[7:0]);
                @(negedge clk);
                chk("R9 smi_req single cycle", {7'd0, smi_req}, 8'h00);
            end
            wr(3'd2, 8'h00); rd(3'd2, r);
            chk("R7 gbl still frozen", r, 8'h01);
            exp_smi_en = 8'h01;
            wr(3'd1, ON_C); // re-enter mode so next sweep sees toggles both ways
            exp_acpi = 1'b1;
        end

        // R8 base masking
        for (int v = 0; v < 256; v++) begin
            wr(3'd4, v[7:0]); rd(3'd4, r); chk("R8 base low masked", r, v[7:0] & 8'h80);
            wr(3'd5, v[7:0]); rd(3'd5, r); chk("R8 base high kept", r, v[7:0]);
        end

        // R1/R6 reset clears lock and everything
        do_reset();
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            chk("R1 second reset value", r, 8'h00);
        end
        chk("R1 acpi cleared", {7'd0, acpi_mode}, 8'h00);
        wr(3'd2, 8'h01); wr(3'd2, 8'h00); rd(3'd2, r);
        chk("R6 lock gone after reset", r, 8'h00);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule